// File: doc/BRIEF.md
# BF16 Immediate Floating-Point Register Loader

This block executes two load-immediate operations that target a 64-bit floating-point register. Each operation arrives as one 32-bit instruction word. A 16-bit immediate is spread over three fields of that word, and the block gathers it into one bfloat16 value. The "shifted" operation puts that value in the upper half of a single-precision word, fills the lower half with zeros, widens the word to double precision and writes it to the destination register. The "second-half" operation reads the destination register and narrows it to single format. It then replaces the low 16 bits of the single value with the immediate and widens the result back to double. A pair of these operations builds any single-precision constant in two instructions without a data load.

Results leave through a registered write-back port one cycle after the instruction is accepted. The register file sits outside the block. The block presents the destination index on a read port and takes the register contents back combinationally. A result still in the write-back stage is forwarded when the next instruction reads the same register. Neither operation touches any status or flag state.

The control is a two-state machine. `S_IDLE` means no result is pending. `S_EMIT` means the write-back register holds a valid result. Transition *accept* (`S_IDLE`→`S_EMIT`) fires on a valid, recognised instruction. Transition *chain* (`S_EMIT`→`S_EMIT`) fires when a new recognised instruction arrives while a result is being written. Transition *drain* (`S_EMIT`→`S_IDLE`) fires when no recognised instruction arrives. Transition *hold* (`S_IDLE`→`S_IDLE`) covers all other idle cycles.

Top module: `bf16_fpr_loader`

## Requirements
- R1: Bits are numbered `in_insn[31:0]`. The primary opcode is `in_insn[31:26]` and must equal 59. The destination index is `in_insn[25:21]`. The sub-opcode is `in_insn[5:1]`: 8 selects shifted and 9 selects second-half. The immediate is `{in_insn[15:6], in_insn[20:16], in_insn[0]}`. `rd_idx` always shows the destination index of the current `in_insn`.
- R2: The shifted operation writes the double equal to the single word `{imm, 16'h0000}`. For example, 0x3F80 gives 0x3FF0000000000000, 0xBFC0 gives 0xBFF8000000000000, 0x8000 gives 0x8000000000000000 and 0x3FFF gives 0x3FFFE00000000000.
- R3: Widening a normal single adds 896 to the exponent and left-aligns the 23-bit fraction in the 52-bit field. Exponent 255 becomes 2047 with the fraction left-aligned, so 0x7F80 gives 0x7FF0000000000000 and 0x7FC0 gives 0x7FF8000000000000. A zero keeps its sign.
- R4: Widening a single denormal normalises it to an exact double. For example, single 0x00000001 becomes 0x36A0000000000000.
- R5: Narrowing a double uses no rounding. An exponent above 896, or an all-zero magnitude, maps to `{d[63:62], d[58:29]}`. An exponent from 874 to 896 gives a single denormal equal to `{1, d[51:29]}` shifted right by 897 minus the exponent. Any other exponent gives a zero with the sign kept.
- R6: The second-half operation replaces bits [15:0] of the narrowed single with the immediate and widens the result. Shifted 0x3F80 followed by second-half 0x8000 on one register leaves 0x3FF0100000000000.
- R7: A recognised instruction with `in_valid` high produces exactly one `wb_valid` pulse on the next cycle, with `wb_idx` equal to its destination index.
- R8: When a second-half instruction follows in the cycle right after a write-back to the same register, it uses the pending `wb_data` instead of `rd_data`.
- R9: An instruction with a wrong primary opcode, a wrong sub-opcode, or `in_valid` low produces no write-back and leaves every register value unchanged.
- R10: While `rst_n` is low and after it is released, `wb_valid` is low until a recognised instruction arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word is valid this cycle |
| in_insn | input | 32 | Instruction word |
| rd_idx | output | 5 | Register index to read (destination field) |
| rd_data | input | 64 | Contents of register `rd_idx` |
| wb_valid | output | 1 | Write-back strobe |
| wb_idx | output | 5 | Register index to write |
| wb_data | output | 64 | Double-precision value to write |

## Verification
The bench drives shifted operations followed immediately by second-half operations on the same register. A design without forwarding would then merge the immediate into a stale register value. It creates single denormals by merging small immediates into a zero. A widener that skipped normalisation would write a wrong exponent, or a fraction with the hidden bit still in it. The denormal is then fed back through narrowing, so a truncating narrower that ignored the denormal range would return zero. Infinity and NaN payloads, signed zeros, and a truncated non-single constant expose exponent-rebias and rounding mistakes. Instructions with a wrong opcode, a wrong sub-opcode, or no valid strobe must leave no write-back and must leave the later register contents unchanged.

// File: rtl/bfl_pkg.sv
package bfl_pkg;
    localparam int SP_W      = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_W      = 64;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int FRAC_PAD  = DP_FRAC_W - SP_FRAC_W;
    localparam int BIAS_GAP  = 1023 - 127;
    localparam int LZ_W      = $clog2(SP_FRAC_W);

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SHIFTED,
        OP_SECOND
    } op_e;

    typedef enum logic {
        S_IDLE,
        S_EMIT
    } st_e;
endpackage

// File: rtl/bfl_decode.sv
module bfl_decode
    import bfl_pkg::*;
#(
    parameter int INSN_W     = 32,
    parameter int IDX_W      = 5,
    parameter int IMM_W      = 16,
    parameter int MAJOR_W    = 6,
    parameter int XO_W       = 5,
    parameter logic [5:0] MAJOR_OP   = 6'd59,
    parameter logic [4:0] XO_SHIFTED = 5'd8,
    parameter logic [4:0] XO_SECOND  = 5'd9
) (
    input  logic [INSN_W-1:0] insn,
    output op_e               op,
    output logic [IDX_W-1:0]  frt,
    output logic [IMM_W-1:0]  imm
);
    localparam int FRT_LSB = INSN_W - MAJOR_W - IDX_W;
    localparam int D1_LSB  = FRT_LSB - IDX_W;
    localparam int D0_W    = IMM_W - IDX_W - 1;
    localparam int D0_LSB  = D1_LSB - D0_W;

    logic [MAJOR_W-1:0] major;
    logic [XO_W-1:0]    xo;

    assign major = insn[INSN_W-1 -: MAJOR_W];
    assign frt   = insn[FRT_LSB +: IDX_W];
    assign xo    = insn[XO_W:1];
    assign imm   = {insn[D0_LSB +: D0_W], insn[D1_LSB +: IDX_W], insn[0]};

    always_comb begin
        op = OP_NONE;
        if (major == MAJOR_OP) begin
            if (xo == XO_SHIFTED)
                op = OP_SHIFTED;
            else if (xo == XO_SECOND)
                op = OP_SECOND;
        end
    end
endmodule

// File: rtl/bfl_narrow.sv
module bfl_narrow
    import bfl_pkg::*;
(
    input  logic [DP_W-1:0] dbl,
    output logic [SP_W-1:0] sgl
);
    localparam logic [DP_EXP_W-1:0] NORM_FLOOR = DP_EXP_W'(BIAS_GAP);
    localparam logic [DP_EXP_W-1:0] DEN_FLOOR  = DP_EXP_W'(BIAS_GAP - SP_FRAC_W + 1);
    localparam logic [DP_EXP_W-1:0] DEN_BASE   = DP_EXP_W'(BIAS_GAP + 1);

    logic                 sign;
    logic [DP_EXP_W-1:0]  dexp;
    logic [DP_FRAC_W-1:0] dfrac;
    logic [DP_EXP_W-1:0]  sh_full;
    logic [LZ_W-1:0]      sh;
    logic [SP_FRAC_W:0]   mant;
    logic                 unused_low;

    assign sign       = dbl[DP_W-1];
    assign dexp       = dbl[DP_W-2 -: DP_EXP_W];
    assign dfrac      = dbl[DP_FRAC_W-1:0];
    assign sh_full    = DEN_BASE - dexp;
    assign sh         = sh_full[LZ_W-1:0];
    assign mant       = {1'b1, dfrac[DP_FRAC_W-1 -: SP_FRAC_W]} >> sh;
    assign unused_low = ^{dfrac[FRAC_PAD-1:0], sh_full[DP_EXP_W-1:LZ_W]};

    always_comb begin
        if (dexp > NORM_FLOOR || dbl[DP_W-2:0] == '0)
            sgl = {dbl[DP_W-1:DP_W-2], dbl[DP_W-6:FRAC_PAD]};
        else if (dexp >= DEN_FLOOR)
            sgl = {sign, {SP_EXP_W{1'b0}}, mant[SP_FRAC_W-1:0]};
        else
            sgl = {sign, {(SP_W-1){1'b0}}};
    end
endmodule

// File: rtl/bfl_widen.sv
module bfl_widen
    import bfl_pkg::*;
(
    input  logic [SP_W-1:0] sgl,
    output logic [DP_W-1:0] dbl
);
    logic                 sign;
    logic [SP_EXP_W-1:0]  sexp;
    logic [SP_FRAC_W-1:0] sfrac;
    logic [LZ_W-1:0]      lz;
    logic [LZ_W:0]        shamt;
    logic [SP_FRAC_W-1:0] norm;
    logic [DP_EXP_W-1:0]  den_exp;
    logic [DP_EXP_W-1:0]  nrm_exp;

    assign sign  = sgl[SP_W-1];
    assign sexp  = sgl[SP_W-2 -: SP_EXP_W];
    assign sfrac = sgl[SP_FRAC_W-1:0];

    always_comb begin
        lz = '0;
        for (int i = 0; i < SP_FRAC_W; i++) begin
            if (sfrac[i])
                lz = LZ_W'(SP_FRAC_W - 1 - i);
        end
    end

    assign shamt   = {1'b0, lz} + 1'b1;
    assign norm    = sfrac << shamt;
    assign den_exp = DP_EXP_W'(BIAS_GAP) - {{(DP_EXP_W-LZ_W){1'b0}}, lz};
    assign nrm_exp = {{(DP_EXP_W-SP_EXP_W){1'b0}}, sexp} + DP_EXP_W'(BIAS_GAP);

    always_comb begin
        if (sexp == '1)
            dbl = {sign, {DP_EXP_W{1'b1}}, sfrac, {FRAC_PAD{1'b0}}};
        else if (sexp == '0 && sfrac == '0)
            dbl = {sign, {(DP_W-1){1'b0}}};
        else if (sexp == '0)
            dbl = {sign, den_exp, norm, {FRAC_PAD{1'b0}}};
        else
            dbl = {sign, nrm_exp, sfrac, {FRAC_PAD{1'b0}}};
    end
endmodule

// File: rtl/bf16_fpr_loader.sv
module bf16_fpr_loader
    import bfl_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int IDX_W  = 5,
    parameter int IMM_W  = 16,
    parameter logic [5:0] MAJOR_OP   = 6'd59,
    parameter logic [4:0] XO_SHIFTED = 5'd8,
    parameter logic [4:0] XO_SECOND  = 5'd9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_insn,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [DP_W-1:0]   rd_data,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DP_W-1:0]   wb_data
);
    localparam int KEEP_W = SP_W - IMM_W;

    op_e              op;
    logic [IDX_W-1:0] frt;
    logic [IMM_W-1:0] imm;
    logic             accept;
    logic [DP_W-1:0]  operand;
    logic [SP_W-1:0]  narrowed;
    logic [SP_W-1:0]  merged;
    logic [DP_W-1:0]  result;
    st_e              state;
    st_e              nxt;

    bfl_decode #(
        .INSN_W     (INSN_W),
        .IDX_W      (IDX_W),
        .IMM_W      (IMM_W),
        .MAJOR_OP   (MAJOR_OP),
        .XO_SHIFTED (XO_SHIFTED),
        .XO_SECOND  (XO_SECOND)
    ) u_decode (
        .insn (in_insn),
        .op   (op),
        .frt  (frt),
        .imm  (imm)
    );

    assign rd_idx  = frt;
    assign accept  = in_valid && (op != OP_NONE);
    assign operand = (state == S_EMIT && wb_idx == frt) ? wb_data : rd_data;

    bfl_narrow u_narrow (
        .dbl (operand),
        .sgl (narrowed)
    );

    assign merged = (op == OP_SHIFTED) ? {imm, {KEEP_W{1'b0}}}
                                       : {narrowed[SP_W-1 -: KEEP_W], imm};

    bfl_widen u_widen (
        .sgl (merged),
        .dbl (result)
    );

    always_comb begin
        unique case (state)
            S_IDLE:  nxt = accept ? S_EMIT : S_IDLE;
            S_EMIT:  nxt = accept ? S_EMIT : S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_idx  <= '0;
            wb_data <= '0;
        end else if (accept) begin
            wb_idx  <= frt;
            wb_data <= result;
        end
    end

    assign wb_valid = (state == S_EMIT);

    assert_wb_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> wb_valid);

    assert_wb_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> wb_idx == $past(frt));

    assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !wb_valid);

    assert_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SHIFTED) |=> wb_data[DP_W-1] == $past(imm[IMM_W-1]));

    assert_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_data[FRAC_PAD-1:0] == '0);

    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> !wb_valid);
endmodule

// File: tb/bf16_fpr_loader_tb.sv
`timescale 1ns/1ps
module bf16_fpr_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic [4:0]  rd_idx;
    logic [63:0] rd_data;
    logic        wb_valid;
    logic [4:0]  wb_idx;
    logic [63:0] wb_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [63:0] rf [32];
    logic [63:0] shadow [32];

    int          due_q [$];
    logic [4:0]  idx_q [$];
    logic [63:0] data_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    bf16_fpr_loader u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_insn  (in_insn),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .wb_valid (wb_valid),
        .wb_idx   (wb_idx),
        .wb_data  (wb_data)
    );

    assign rd_data = rf[rd_idx];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wb_valid) rf[wb_idx] <= wb_data;
    end

    function automatic logic [63:0] ref_widen(input logic [31:0] s);
        logic [23:0] m;
        int ue;
        if (s[30:23] == 8'hFF) return {s[31], 11'h7FF, s[22:0], 29'h0};
        if (s[30:0] == 31'h0) return {s[31], 63'h0};
        m  = {(s[30:23] != 8'h0), s[22:0]};
        ue = (s[30:23] == 8'h0) ? -126 : int'(s[30:23]) - 127;
        while (!m[23]) begin
            m = m << 1;
            ue = ue - 1;
        end
        return {s[31], 11'(ue + 1023), m[22:0], 29'h0};
    endfunction

    function automatic logic [31:0] ref_narrow(input logic [63:0] d);
        logic [23:0] m;
        int ue;
        if (d[62:52] == 11'h0) return {d[63], 31'h0};
        if (d[62:52] == 11'h7FF) return {d[63], 8'hFF, d[51:29]};
        ue = int'(d[62:52]) - 1023;
        if (ue >= -126) return {d[63], 8'(ue + 127), d[51:29]};
        if (ue < -149) return {d[63], 31'h0};
        m = {1'b1, d[51:29]};
        for (int k = 0; k < -126 - ue; k++) m = m >> 1;
        return {d[63], 8'h0, m[22:0]};
    endfunction

    // kind: 0 shifted, 1 second-half, 2 wrong opcode, 3 wrong sub-opcode, 4 valid low
    task automatic issue(input int kind, input logic [4:0] frt, input logic [15:0] imm,
                         input bit use_lit, input logic [63:0] lit, input string tag);
        logic [5:0]  opc;
        logic [4:0]  xo;
        logic [63:0] expv;
        opc = (kind == 2) ? 6'd58 : 6'd59;
        xo  = (kind == 1) ? 5'd9 : (kind == 3) ? 5'd10 : 5'd8;
        @(negedge clk);
        in_insn  = {opc, frt, imm[5:1], imm[15:6], xo, imm[0]};
        in_valid = (kind != 4);
        #0.5;
        checks++;
        if (rd_idx !== frt) begin
            fails++;
            $display("FAIL R1 rd_idx actual=%0d expected=%0d", rd_idx, frt);
        end
        if (kind == 0 || kind == 1) begin
            if (kind == 0) expv = ref_widen({imm, 16'h0});
            else           expv = ref_widen({ref_narrow(shadow[frt])[31:16], imm});
            if (use_lit) expv = lit;
            shadow[frt] = expv;
            due_q.push_back(cyc + 1);
            idx_q.push_back(frt);
            data_q.push_back(expv);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_insn  = '0;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (wb_valid) begin
                checks++;
                if (due_q.size() == 0 || due_q[0] != cyc) begin
                    fails++;
                    $display("FAIL R9 unexpected write-back idx=%0d data=%h expected none", wb_idx, wb_data);
                end else begin
                    if (wb_idx !== idx_q[0] || wb_data !== data_q[0]) begin
                        fails++;
                        $display("FAIL %s idx=%0d data=%h expected idx=%0d data=%h",
                                 tag_q[0], wb_idx, wb_data, idx_q[0], data_q[0]);
                    end
                    void'(due_q.pop_front());
                    void'(idx_q.pop_front());
                    void'(data_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end else if (due_q.size() != 0 && due_q[0] <= cyc) begin
                checks++;
                fails++;
                $display("FAIL R7 missing write-back actual=none expected idx=%0d data=%h",
                         idx_q[0], data_q[0]);
                void'(due_q.pop_front());
                void'(idx_q.pop_front());
                void'(data_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    task automatic expect_quiet(input string tag);
        @(negedge clk);
        #0.5;
        checks++;
        if (wb_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s wb_valid actual=%b expected=0", tag, wb_valid);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            rf[i]     = 64'h0;
            shadow[i] = 64'h0;
        end
        rf[7]      = 64'h400921FB54442D18;
        shadow[7]  = 64'h400921FB54442D18;
        rf[9]      = 64'hC05EDD2F1A9FBE77;
        shadow[9]  = 64'hC05EDD2F1A9FBE77;
        rf[11]     = 64'h380FFFFFE0000000;
        shadow[11] = 64'h380FFFFFE0000000;

        repeat (3) @(negedge clk);
        checks++;
        if (wb_valid !== 1'b0) begin
            fails++;
            $display("FAIL R10 wb_valid in reset actual=%b expected=0", wb_valid);
        end
        rst_n = 1'b1;
        expect_quiet("R10");

        // R2 / R3 literal examples
        issue(0, 5'd1, 16'h0000, 1, 64'h0000000000000000, "R3 +0.0");
        issue(0, 5'd2, 16'h8000, 1, 64'h8000000000000000, "R3 -0.0");
        issue(0, 5'd3, 16'h3F80, 1, 64'h3FF0000000000000, "R2 +1.0");
        issue(0, 5'd4, 16'hBFC0, 1, 64'hBFF8000000000000, "R2 -1.5");
        issue(0, 5'd5, 16'h7F80, 1, 64'h7FF0000000000000, "R3 +inf");
        issue(0, 5'd6, 16'hFF80, 1, 64'hFFF0000000000000, "R3 -inf");
        issue(0, 5'd8, 16'h7FC0, 1, 64'h7FF8000000000000, "R3 qNaN");
        issue(0, 5'd10, 16'h3FFF, 1, 64'h3FFFE00000000000, "R2 1.9921875");
        idle(2);

        // R6 / R8 combined example, back-to-back on one register
        issue(0, 5'd12, 16'h3F80, 1, 64'h3FF0000000000000, "R2 upper half");
        issue(1, 5'd12, 16'h8000, 1, 64'h3FF0100000000000, "R8 forwarded merge");
        idle(2);
        // R6 from the register file port (not back-to-back)
        issue(1, 5'd3, 16'h8000, 1, 64'h3FF0100000000000, "R6 merge via read port");
        idle(2);

        // R4 denormals built from a zero, then R5 narrowing of the denormal
        issue(1, 5'd1, 16'h0001, 1, 64'h36A0000000000000, "R4 min denormal");
        issue(1, 5'd1, 16'h0003, 1, 64'h36B8000000000000, "R5 narrow denormal forwarded");
        idle(1);
        issue(1, 5'd2, 16'h8000, 1, 64'hB790000000000000, "R4 negative denormal");
        idle(1);
        issue(1, 5'd2, 16'h00FF, 0, 64'h0, "R5 denormal via read port");
        idle(1);
        issue(1, 5'd11, 16'h1234, 0, 64'h0, "R5 denormal-range double");

        // R3 NaN payload through second-half, R5 truncation of non-single values
        issue(1, 5'd5, 16'h0001, 1, 64'h7FF0000020000000, "R3 NaN payload");
        issue(1, 5'd7, 16'h1234, 0, 64'h0, "R5 truncated pi");
        issue(1, 5'd9, 16'hFFFF, 0, 64'h0, "R5 negative truncation");
        idle(1);

        // R7 back-to-back to different registers: no forwarding mix-up
        issue(0, 5'd20, 16'h4049, 0, 64'h0, "R7 chain a");
        issue(1, 5'd21, 16'h4000, 0, 64'h0, "R7 chain b");
        issue(1, 5'd20, 16'h0FDB, 0, 64'h0, "R8 chain c");
        idle(2);

        // R9 ignored instructions, then prove register 20 unchanged
        issue(2, 5'd20, 16'h1111, 0, 64'h0, "R9");
        expect_quiet("R9 wrong opcode");
        issue(3, 5'd20, 16'h2222, 0, 64'h0, "R9");
        expect_quiet("R9 wrong sub-opcode");
        issue(4, 5'd20, 16'h3333, 0, 64'h0, "R9");
        expect_quiet("R9 valid low");
        issue(1, 5'd20, 16'h0FDB, 0, 64'h0, "R9 register untouched");
        idle(3);

        checks++;
        if (due_q.size() != 0) begin
            fails++;
            $display("FAIL R7 pending results actual=%0d expected=0", due_q.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R7 watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule